// File: doc/BRIEF.md
# Binary Vector Dot-Product Accumulator

This unit takes two bit vectors one 128-bit word pair at a time and returns their dot product. Since every element is 0 or 1, the dot product is the number of bit positions set in both vectors. Each accepted pair goes through three registered stages: a bitwise AND, a set-bit count taken separately in each byte lane, and an add of those 16 counts into narrow 8-bit lane accumulators.

Consecutive words are dealt round-robin to six independent accumulator sets. A set is therefore updated at most once every six words, and no add ever needs the result of the add just before it, so there is no forwarding path. Each set counts the words it has absorbed. On its 31st word it folds its byte lanes into 16-bit lane totals and clears them, before an 8-bit lane can overflow.

A vector is a stream of word pairs on a valid/ready input, and the final pair carries a last flag. Once that pair has drained, every set folds what is left. All lane totals of all sets are then added into one 32-bit result, and a one-cycle done pulse marks it valid. A vector whose length is not a whole number of six-word chunks is still summed, but it is flagged with an error bit alongside done.

Top module: `bvdot`

## Requirements
- R1: After done, `res` equals the number of bit positions that are 1 in both `in_a` and `in_b`, summed over every word pair accepted for that vector, in which a pair is accepted on a rising clock edge with `in_valid` and `in_ready` both high.
- R2: The result stays exact when any accumulator set absorbs more than 31 words. For example, 384 all-ones pairs give 49152.
- R3: While a vector is being streamed, `in_ready` stays high, so one word pair can be accepted on every cycle with no stall until the last pair.
- R4: From the cycle after the pair with `in_last` high is accepted, `in_ready` is low. It returns high only in the cycle in which `done` is high.
- R5: `done` is high for exactly one cycle per vector, and `res` changes only in a cycle in which `done` is high.
- R6: If the pair marked last is not the 6k-th pair of its vector (k ≥ 1), `err` is 1 in the done cycle. Otherwise `err` is 0 there. `err` is never 1 outside a done cycle.
- R7: During and right after synchronous reset, `in_ready` is 1 and `done`, `err` and `res` are 0.
- R8: Each vector's result depends only on its own pairs. Nothing from earlier vectors carries over.
- R9: Idle cycles with `in_valid` low between pairs of a vector do not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A word pair is offered |
| in_ready | output | 1 | The unit takes the offered pair on this edge |
| in_last | input | 1 | The offered pair ends the vector |
| in_a | input | 128 | Operand word A |
| in_b | input | 128 | Operand word B |
| res | output | 32 | Dot product of the most recent vector |
| done | output | 1 | One-cycle pulse: `res` and `err` are valid |
| err | output | 1 | Vector length was not a multiple of six words |

## Verification
The lane fold and the arrival of the final word can fall in the same cycle. A 186-word all-ones vector gives each set exactly 31 words, so every set folds on its own last word and the end-of-vector fold then finds empty lanes. The expected total is 186 × 128 = 23808, and a fold that is lost or applied twice would show up as a difference there. A 384-word all-ones vector makes every set fold twice during streaming and once more at the end, with an expected total of 49152. Random vectors, with and without idle gaps, are compared against a count of the ANDed words made in the bench.

// File: rtl/bvdot.sv
module bvdot #(
  parameter int W    = 128,
  parameter int SETS = 6,
  parameter int FOLD = 31,
  parameter int TW   = 16,
  parameter int RW   = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_last,
  input  logic [W-1:0]  in_a,
  input  logic [W-1:0]  in_b,
  output logic [RW-1:0] res,
  output logic          done,
  output logic          err
);
  localparam int L  = W / 8;
  localparam int SW = $clog2(SETS);
  localparam int CW = $clog2(FOLD + 1);

  typedef enum logic [1:0] {RUN, DRAIN, FLUSH, SUM} st_t;
  st_t st;

  logic [W-1:0]  s1_and;
  logic          s1_v, s2_v;
  logic [SW-1:0] s1_set, s2_set, sidx;
  logic [3:0]    pc   [L];
  logic [3:0]    s2_pc[L];
  logic [7:0]    acc  [SETS][L];
  logic [TW-1:0] tot  [SETS][L];
  logic [CW-1:0] cnt  [SETS];
  logic          err_q;
  logic [RW-1:0] sum;

  wire accept = in_valid && in_ready;
  assign in_ready = (st == RUN);

  always_comb begin
    for (int l = 0; l < L; l++) begin
      pc[l] = '0;
      for (int b = 0; b < 8; b++) pc[l] = pc[l] + {3'b0, s1_and[8*l+b]};
    end
  end

  always_comb begin
    sum = '0;
    for (int s = 0; s < SETS; s++)
      for (int l = 0; l < L; l++) sum = sum + RW'(tot[s][l]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0; s2_v <= 1'b0;
      s1_and <= '0; s1_set <= '0; s2_set <= '0;
      for (int l = 0; l < L; l++) s2_pc[l] <= '0;
    end else begin
      s1_v   <= accept;
      s1_and <= in_a & in_b;
      s1_set <= sidx;
      s2_v   <= s1_v;
      s2_set <= s1_set;
      for (int l = 0; l < L; l++) s2_pc[l] <= pc[l];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || st == SUM) begin
      for (int s = 0; s < SETS; s++) begin
        cnt[s] <= '0;
        for (int l = 0; l < L; l++) begin
          acc[s][l] <= '0;
          tot[s][l] <= '0;
        end
      end
    end else if (st == FLUSH) begin
      for (int s = 0; s < SETS; s++) begin
        cnt[s] <= '0;
        for (int l = 0; l < L; l++) begin
          tot[s][l] <= tot[s][l] + TW'(acc[s][l]);
          acc[s][l] <= '0;
        end
      end
    end else if (s2_v) begin
      for (int s = 0; s < SETS; s++) begin
        if (SW'(s) == s2_set) begin
          if (cnt[s] == CW'(FOLD - 1)) begin
            cnt[s] <= '0;
            for (int l = 0; l < L; l++) begin
              tot[s][l] <= tot[s][l] + TW'(acc[s][l]) + TW'(s2_pc[l]);
              acc[s][l] <= '0;
            end
          end else begin
            cnt[s] <= cnt[s] + 1'b1;
            for (int l = 0; l < L; l++) acc[s][l] <= acc[s][l] + 8'(s2_pc[l]);
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= RUN; sidx <= '0; err_q <= 1'b0;
      res <= '0; done <= 1'b0; err <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (accept) begin
        sidx <= (sidx == SW'(SETS - 1)) ? '0 : sidx + 1'b1;
        if (in_last && sidx != SW'(SETS - 1)) err_q <= 1'b1;
      end
      case (st)
        RUN:   if (accept && in_last) st <= DRAIN;
        DRAIN: if (!s1_v && !s2_v) st <= FLUSH;
        FLUSH: st <= SUM;
        SUM: begin
          st    <= RUN;
          res   <= sum;
          done  <= 1'b1;
          err   <= err_q;
          err_q <= 1'b0;
          sidx  <= '0;
        end
        default: st <= RUN;
      endcase
    end
  end
endmodule

module bvdot_chk #(parameter int RW = 32) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_last,
  input logic [RW-1:0] res,
  input logic          done,
  input logic          err
);
  p_ready_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_last) |=> !in_ready);
  p_ready_return_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(in_ready) |-> done);
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_res_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(res));
  p_err_only_done_r6: assert property (@(posedge clk) disable iff (rst)
    err |-> done);
  p_done_ready_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> in_ready);
endmodule

bind bvdot bvdot_chk #(.RW(RW)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_last(in_last), .res(res), .done(done), .err(err)
);

// File: tb/bvdot_tb_top.sv
module bvdot_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 128;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid, in_last;
  logic          in_ready;
  logic [W-1:0]  in_a, in_b;
  logic [31:0]   res;
  logic          done, err;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bvdot dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_last(in_last), .in_a(in_a), .in_b(in_b),
    .res(res), .done(done), .err(err)
  );

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rnd();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // mode 0 random, 1 all ones, 2 zeros
  task automatic run_vec(input string req, input int n, input int mode, input bit gaps);
    longint exp = 0;
    int stalls = 0;
    int waitc = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (gaps && ($urandom % 3 == 0)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      case (mode)
        1: begin in_a = '1; in_b = '1; end
        2: begin in_a = '0; in_b = rnd(); end
        default: begin in_a = rnd(); in_b = rnd(); end
      endcase
      in_valid = 1'b1;
      in_last  = (i == n - 1);
      while (!in_ready) begin stalls++; @(negedge clk); end
      exp += $countones(in_a & in_b);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    check({req, " R4 ready low after last"}, in_ready, 0);
    check({req, " R3 no stall"}, stalls, 0);
    while (!done && waitc < 50) begin @(negedge clk); waitc++; end
    check({req, " R5 done seen"}, done, 1);
    check({req, " R1 result"}, res, exp);
    check({req, " R6 err"}, err, (n % 6 != 0));
    check({req, " R4 ready at done"}, in_ready, 1);
    @(negedge clk);
    check({req, " R5 done single"}, done, 0);
    check({req, " R5 res held"}, res, exp);
    check({req, " R6 err cleared"}, err, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_last = 1'b0; in_a = '0; in_b = '0;
    repeat (3) @(negedge clk);
    check("R7 ready in reset", in_ready, 1);
    check("R7 done in reset", done, 0);
    check("R7 err in reset", err, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R7 ready after reset", in_ready, 1);
    check("R7 res after reset", res, 0);
    check("R7 done after reset", done, 0);

    run_vec("R1 rnd6", 6, 0, 1'b0);
    run_vec("R1 rnd36", 36, 0, 1'b0);
    run_vec("R2 rnd192", 192, 0, 1'b0);
    run_vec("R2 rnd384", 384, 0, 1'b0);
    run_vec("R2 ones384", 384, 1, 1'b0);
    run_vec("R2 ones186", 186, 1, 1'b0);
    run_vec("R8 zeros6", 6, 2, 1'b0);
    run_vec("R8 ones6", 6, 1, 1'b0);
    run_vec("R9 gaps36", 36, 0, 1'b1);
    run_vec("R9 gaps192", 192, 1, 1'b1);
    run_vec("R6 len7", 7, 0, 1'b0);
    run_vec("R6 len1", 1, 1, 1'b0);
    run_vec("R8 after err", 12, 0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule